// File: doc/BRIEF.md
# DRAM Bank State and Command History Tracker

This block sits beside a DRAM command scheduler and keeps the state the scheduler needs when it decides whether a new command may go out. It takes one issued command per cycle: a 4-bit command code, a bank index, a row address, and the command's start and end times as 32-bit cycle counts. From that stream it keeps, for each bank, whether a row is open and which row it is. For every pairing of command type and bank it also records the start time of the latest such command.

Query inputs select a command type and a bank. One cycle later, registered outputs return three values: the newest start time of that command type across all banks, the newest start time of any command in that bank, and the newest start time of any recorded command at all. The same registered stage also returns the open row of the selected bank.

Two bounded histories follow recent activity. One holds activates, keyed by start time. The other holds reads and writes, keyed by end time. A one-cycle cleanup strobe carries a reference time T. It drops expired entries from both histories in a single clock, each history using its own window input. The live entry counts and a sticky overflow flag for each history are visible at all times.

Top module: `bank_cmd_tracker`

## Requirements
- R1: An activate (code 5) with cmd_valid high marks the addressed bank open and stores cmd_row as that bank's row; open_mask bit b belongs to bank b.
- R2: A read with auto-precharge (2), a write with auto-precharge (4), a precharge (6) or a self-refresh entry (9) closes the addressed bank and no other bank.
- R3: A precharge-all (7) closes every bank in the cycle after it is accepted.
- R4: A plain read (1), a plain write (3) and an auto-refresh (8) leave all open flags and rows unchanged. A no-op (0) and the unused codes 10 to 15 change no state at all.
- R5: For each command code from 1 to 9 and each bank, the start time of the most recent such command is stored, and a new issue overwrites it.
- R6: One cycle after q_cmd and q_bank are applied, latest_cmd_q shows the newest stored time for q_cmd over all banks, latest_bank_q shows the newest for q_bank over all codes, and latest_all_q shows the newest over all entries. A q_cmd outside 1 to 9 gives 0.
- R7: Every activate adds its start time to the activate history. On cleanup at T, with T at least act_window, entries whose start is below T minus act_window are removed. When T is below act_window, nothing is removed. act_count gives the number of live entries.
- R8: Codes 1 to 4 add their end time to the transfer history. On cleanup at T, an entry is removed only when its end is below T and T minus its end exceeds xfer_window. xfer_count gives the number of live entries.
- R9: The activate history holds 8 entries and the transfer history 16. They are written in ring order. Writing into a slot that still holds a live entry replaces it and sets that history's overflow flag, which stays set until reset.
- R10: Synchronous reset closes all banks, stores zero as every row and time, empties both histories and clears both overflow flags and all query outputs.
- R11: One cycle after q_bank is applied, open_row_q shows the stored row of that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 4 | Command code |
| cmd_bank | input | 3 | Target bank |
| cmd_row | input | 16 | Row address (used by activate) |
| cmd_start | input | 32 | Command start time |
| cmd_end | input | 32 | Command end time |
| prune_valid | input | 1 | One-cycle cleanup strobe |
| prune_time | input | 32 | Cleanup reference time T |
| act_window | input | 32 | Activate history window |
| xfer_window | input | 32 | Transfer history window |
| q_cmd | input | 4 | Command code to query |
| q_bank | input | 3 | Bank to query |
| open_mask | output | 8 | Open flag per bank |
| open_row_q | output | 16 | Registered row of q_bank |
| latest_cmd_q | output | 32 | Registered newest time for q_cmd |
| latest_bank_q | output | 32 | Registered newest time for q_bank |
| latest_all_q | output | 32 | Registered newest time overall |
| act_count | output | 4 | Live activate entries |
| xfer_count | output | 5 | Live transfer entries |
| act_ovf | output | 1 | Sticky activate history overflow |
| xfer_ovf | output | 1 | Sticky transfer history overflow |

## Verification
The in-line properties run on every cycle. They check the row-state transitions caused by activates, closing commands, precharge-all and the state-neutral codes. They also check that each recorded start time lands in its table cell, that a push into a free slot raises the live count by one, that a cleanup never raises it, and that the overflow flags stay set. Other behaviour depends on the values the scheduler supplies, so only the bench scenarios can show it. That covers the exact window boundaries of both cleanup rules, the rule that nothing is pruned while T is below the window, the three maximum queries over a mixed history, the replacement of the oldest activate once the ring is full, and the return to the cleared state after a reset.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam logic [3:0] K_NOP  = 4'd0;
  localparam logic [3:0] K_RD   = 4'd1;
  localparam logic [3:0] K_RDA  = 4'd2;
  localparam logic [3:0] K_WR   = 4'd3;
  localparam logic [3:0] K_WRA  = 4'd4;
  localparam logic [3:0] K_ACT  = 4'd5;
  localparam logic [3:0] K_PRE  = 4'd6;
  localparam logic [3:0] K_PREA = 4'd7;
  localparam logic [3:0] K_REF  = 4'd8;
  localparam logic [3:0] K_SREF = 4'd9;
  // number of codes that own a column in the issue-time table (1..9)
  localparam int NCMD = 9;
endpackage

// File: rtl/bct_row_state.sv
module bct_row_state
  import bct_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int ROW_W = 16,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [BW-1:0]    rd_bank,
  output logic [NBANK-1:0] open_mask,
  output logic [ROW_W-1:0] rd_row
);
  logic [ROW_W-1:0] row_arr [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             op_r;
    logic [ROW_W-1:0] row_r;
    logic             hit;
    assign hit = cmd_valid && (cmd_bank == BW'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        op_r  <= 1'b0;
        row_r <= '0;
      end else if (cmd_valid) begin
        if (cmd_code == K_PREA) begin
          op_r <= 1'b0;
        end else if (hit) begin
          if (cmd_code == K_ACT) begin
            op_r  <= 1'b1;
            row_r <= cmd_row;
          end else if (cmd_code == K_RDA || cmd_code == K_WRA ||
                       cmd_code == K_PRE || cmd_code == K_SREF) begin
            op_r <= 1'b0;
          end
        end
      end
    end

    assign open_mask[b] = op_r;
    assign row_arr[b]   = row_r;
  end

  assign rd_row = row_arr[rd_bank];

  // R1
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_code == K_ACT |=>
      open_mask[$past(cmd_bank)] && row_arr[$past(cmd_bank)] == $past(cmd_row));

  // R2
  bank_close_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_code == K_RDA || cmd_code == K_WRA ||
                  cmd_code == K_PRE || cmd_code == K_SREF) |=>
      !open_mask[$past(cmd_bank)]);

  // R3
  all_close_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_code == K_PREA |=> open_mask == '0);

  // R4
  state_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid || cmd_code == K_RD || cmd_code == K_WR || cmd_code == K_REF ||
     cmd_code == K_NOP || cmd_code > K_SREF) |=> $stable(open_mask));
endmodule

// File: rtl/bct_issue_table.sv
module bct_issue_table
  import bct_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int TW    = 32,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_code,
  input  logic [BW-1:0] cmd_bank,
  input  logic [TW-1:0] cmd_start,
  input  logic [3:0]    q_cmd,
  input  logic [BW-1:0] q_bank,
  output logic [TW-1:0] max_cmd,
  output logic [TW-1:0] max_bank,
  output logic [TW-1:0] max_all
);
  localparam int CELLS = NCMD * NBANK;
  localparam int IW    = $clog2(CELLS);

  logic [TW-1:0] tbl [CELLS];
  logic          rec;
  logic [IW-1:0] wr_idx;

  assign rec    = cmd_valid && cmd_code != K_NOP && cmd_code <= K_SREF;
  assign wr_idx = IW'((int'(cmd_code) - 1) * NBANK + int'(cmd_bank));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CELLS; i++) tbl[i] <= '0;
    end else if (rec) begin
      tbl[wr_idx] <= cmd_start;
    end
  end

  // strict compare: an equal later entry does not displace the first found
  always_comb begin
    max_cmd  = '0;
    max_bank = '0;
    max_all  = '0;
    for (int c = 0; c < NCMD; c++) begin
      for (int b = 0; b < NBANK; b++) begin
        if (tbl[c*NBANK+b] > max_all) max_all = tbl[c*NBANK+b];
        if (int'(q_cmd) == c + 1 && tbl[c*NBANK+b] > max_cmd)
          max_cmd = tbl[c*NBANK+b];
        if (int'(q_bank) == b && tbl[c*NBANK+b] > max_bank)
          max_bank = tbl[c*NBANK+b];
      end
    end
  end

  // R5
  cell_write_chk: assert property (@(posedge clk) disable iff (rst)
    rec |=> tbl[$past(wr_idx)] == $past(cmd_start));
endmodule

// File: rtl/bct_history.sv
module bct_history #(
  parameter int DEPTH = 8,
  parameter int TW    = 32,
  parameter int MODE  = 0,   // 0: drop by start vs window; 1: drop by end vs window
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [TW-1:0] key,
  input  logic          prune,
  input  logic [TW-1:0] prune_t,
  input  logic [TW-1:0] window,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TW-1:0]    key_mem [DEPTH];
  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] drop;
  logic [PW-1:0]    wp;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rule
    if (MODE == 0) begin : g_start
      assign drop[i] = prune && (prune_t >= window) && (key_mem[i] < prune_t - window);
    end else begin : g_end
      assign drop[i] = prune && (key_mem[i] < prune_t) && ((prune_t - key_mem[i]) > window);
    end
  end

  always_ff @(posedge clk) begin
    if (push) key_mem[wp] <= key;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      wp   <= '0;
      ovf  <= 1'b0;
    end else begin
      live <= live & ~drop;
      if (push) begin
        live[wp] <= 1'b1;
        wp       <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (live[wp]) ovf <= 1'b1;
      end
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++) count = count + CW'(live[i]);
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R9
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    push && count == CW'(DEPTH) |=> ovf);

  // R7
  push_grow_chk: assert property (@(posedge clk) disable iff (rst)
    push && !prune && !live[wp] |=> count == $past(count) + 1'b1);

  // R8
  prune_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    prune && !push |=> count <= $past(count));
endmodule

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker
  import bct_pkg::*;
#(
  parameter int NBANK      = 8,
  parameter int ROW_W      = 16,
  parameter int TW         = 32,
  parameter int ACT_DEPTH  = 8,
  parameter int XFER_DEPTH = 16,
  parameter int BW         = $clog2(NBANK),
  parameter int ACW        = $clog2(ACT_DEPTH + 1),
  parameter int XCW        = $clog2(XFER_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [TW-1:0]    cmd_start,
  input  logic [TW-1:0]    cmd_end,
  input  logic             prune_valid,
  input  logic [TW-1:0]    prune_time,
  input  logic [TW-1:0]    act_window,
  input  logic [TW-1:0]    xfer_window,
  input  logic [3:0]       q_cmd,
  input  logic [BW-1:0]    q_bank,
  output logic [NBANK-1:0] open_mask,
  output logic [ROW_W-1:0] open_row_q,
  output logic [TW-1:0]    latest_cmd_q,
  output logic [TW-1:0]    latest_bank_q,
  output logic [TW-1:0]    latest_all_q,
  output logic [ACW-1:0]   act_count,
  output logic [XCW-1:0]   xfer_count,
  output logic             act_ovf,
  output logic             xfer_ovf
);
  logic [ROW_W-1:0] sel_row;
  logic [TW-1:0]    m_cmd, m_bank, m_all;
  logic             act_push, xfer_push;

  assign act_push  = cmd_valid && cmd_code == K_ACT;
  assign xfer_push = cmd_valid && (cmd_code == K_RD || cmd_code == K_RDA ||
                                   cmd_code == K_WR || cmd_code == K_WRA);

  bct_row_state #(.NBANK(NBANK), .ROW_W(ROW_W), .BW(BW)) u_rows (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .rd_bank(q_bank),
    .open_mask(open_mask), .rd_row(sel_row)
  );

  bct_issue_table #(.NBANK(NBANK), .TW(TW), .BW(BW)) u_table (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_start(cmd_start), .q_cmd(q_cmd), .q_bank(q_bank),
    .max_cmd(m_cmd), .max_bank(m_bank), .max_all(m_all)
  );

  bct_history #(.DEPTH(ACT_DEPTH), .TW(TW), .MODE(0), .CW(ACW)) u_act_hist (
    .clk(clk), .rst(rst), .push(act_push), .key(cmd_start),
    .prune(prune_valid), .prune_t(prune_time), .window(act_window),
    .count(act_count), .ovf(act_ovf)
  );

  bct_history #(.DEPTH(XFER_DEPTH), .TW(TW), .MODE(1), .CW(XCW)) u_xfer_hist (
    .clk(clk), .rst(rst), .push(xfer_push), .key(cmd_end),
    .prune(prune_valid), .prune_t(prune_time), .window(xfer_window),
    .count(xfer_count), .ovf(xfer_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      open_row_q    <= '0;
      latest_cmd_q  <= '0;
      latest_bank_q <= '0;
      latest_all_q  <= '0;
    end else begin
      open_row_q    <= sel_row;
      latest_cmd_q  <= m_cmd;
      latest_bank_q <= m_bank;
      latest_all_q  <= m_all;
    end
  end
endmodule

// File: tb/bank_cmd_tracker_tb.sv
module bank_cmd_tracker_tb_top;
  localparam int NB = 8, RW = 16, NC = 9, AD = 8, XD = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, cmd_valid = 1'b0, prune_valid = 1'b0;
  logic [3:0] cmd_code = '0, q_cmd = '0;
  logic [2:0] cmd_bank = '0, q_bank = '0;
  logic [RW-1:0] cmd_row = '0;
  logic [31:0] cmd_start = '0, cmd_end = '0, prune_time = '0;
  logic [31:0] act_window = 32'd40, xfer_window = 32'd25;
  logic [NB-1:0] open_mask;
  logic [RW-1:0] open_row_q;
  logic [31:0] latest_cmd_q, latest_bank_q, latest_all_q;
  logic [3:0] act_count;
  logic [4:0] xfer_count;
  logic act_ovf, xfer_ovf;

  bank_cmd_tracker dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_start(cmd_start), .cmd_end(cmd_end),
    .prune_valid(prune_valid), .prune_time(prune_time), .act_window(act_window),
    .xfer_window(xfer_window), .q_cmd(q_cmd), .q_bank(q_bank), .open_mask(open_mask),
    .open_row_q(open_row_q), .latest_cmd_q(latest_cmd_q), .latest_bank_q(latest_bank_q),
    .latest_all_q(latest_all_q), .act_count(act_count), .xfer_count(xfer_count),
    .act_ovf(act_ovf), .xfer_ovf(xfer_ovf)
  );

  // reference model
  bit m_open [NB];
  logic [RW-1:0] m_row [NB];
  logic [31:0] m_tbl [NC][NB];
  logic [31:0] m_ak [AD];
  bit m_av [AD];
  int m_ap;
  bit m_ao;
  logic [31:0] m_xk [XD];
  bit m_xv [XD];
  int m_xp;
  bit m_xo;
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0;
      m_row[b] = '0;
      for (int c = 0; c < NC; c++) m_tbl[c][b] = '0;
    end
    for (int i = 0; i < AD; i++) m_av[i] = 0;
    for (int i = 0; i < XD; i++) m_xv[i] = 0;
    m_ap = 0; m_xp = 0; m_ao = 0; m_xo = 0;
  endtask

  task automatic model_cmd(input logic [3:0] code, input int bank, input logic [RW-1:0] row,
                           input logic [31:0] s, input logic [31:0] e);
    int c;
    c = int'(code);
    if (c >= 1 && c <= 9) m_tbl[c-1][bank] = s;
    if (c == 5) begin m_open[bank] = 1; m_row[bank] = row; end
    if (c == 2 || c == 4 || c == 6 || c == 9) m_open[bank] = 0;
    if (c == 7) for (int b = 0; b < NB; b++) m_open[b] = 0;
    if (c == 5) begin
      if (m_av[m_ap]) m_ao = 1;
      m_ak[m_ap] = s; m_av[m_ap] = 1; m_ap = (m_ap + 1) % AD;
    end
    if (c >= 1 && c <= 4) begin
      if (m_xv[m_xp]) m_xo = 1;
      m_xk[m_xp] = e; m_xv[m_xp] = 1; m_xp = (m_xp + 1) % XD;
    end
  endtask

  task automatic model_prune(input logic [31:0] t);
    for (int i = 0; i < AD; i++)
      if (m_av[i] && t >= act_window && m_ak[i] < t - act_window) m_av[i] = 0;
    for (int i = 0; i < XD; i++)
      if (m_xv[i] && m_xk[i] < t && (t - m_xk[i]) > xfer_window) m_xv[i] = 0;
  endtask

  function automatic logic [31:0] f_cmd(input logic [3:0] q);
    logic [31:0] m = '0;
    if (q >= 4'd1 && q <= 4'd9)
      for (int b = 0; b < NB; b++) if (m_tbl[int'(q)-1][b] > m) m = m_tbl[int'(q)-1][b];
    return m;
  endfunction

  function automatic logic [31:0] f_bank(input int b);
    logic [31:0] m = '0;
    for (int c = 0; c < NC; c++) if (m_tbl[c][b] > m) m = m_tbl[c][b];
    return m;
  endfunction

  function automatic logic [31:0] f_all();
    logic [31:0] m = '0;
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) if (m_tbl[c][b] > m) m = m_tbl[c][b];
    return m;
  endfunction

  function automatic int f_acnt();
    int n = 0;
    for (int i = 0; i < AD; i++) n += int'(m_av[i]);
    return n;
  endfunction

  function automatic int f_xcnt();
    int n = 0;
    for (int i = 0; i < XD; i++) n += int'(m_xv[i]);
    return n;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b0; prune_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic do_cmd(input logic [3:0] code, input int bank, input logic [RW-1:0] row,
                        input logic [31:0] s, input logic [31:0] e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_bank = 3'(bank);
    cmd_row = row; cmd_start = s; cmd_end = e;
    model_cmd(code, bank, row, s, e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_prune(input logic [31:0] t);
    @(negedge clk);
    prune_valid = 1'b1; prune_time = t;
    model_prune(t);
    @(negedge clk);
    prune_valid = 1'b0;
  endtask

  // apply a query, let the output stage register it, then compare everything
  task automatic compare(input logic [3:0] qc, input int qb);
    logic [NB-1:0] em;
    q_cmd = qc; q_bank = 3'(qb);
    @(negedge clk);
    for (int b = 0; b < NB; b++) em[b] = m_open[b];
    chk("R1 R2 R3 R4 open mask", 32'(open_mask), 32'(em));
    chk("R11 open row", 32'(open_row_q), 32'(m_row[qb]));
    chk("R6 R5 latest by command", latest_cmd_q, f_cmd(qc));
    chk("R6 R5 latest by bank", latest_bank_q, f_bank(qb));
    chk("R6 R5 latest overall", latest_all_q, f_all());
    chk("R7 activate count", 32'(act_count), 32'(f_acnt()));
    chk("R8 transfer count", 32'(xfer_count), 32'(f_xcnt()));
    chk("R9 activate overflow", 32'(act_ovf), 32'(m_ao));
    chk("R9 transfer overflow", 32'(xfer_ovf), 32'(m_xo));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] now;
    int unused_seed;
    unused_seed = int'($urandom(32'h1d5a));
    model_clear();
    do_reset();
    // R10 reset state
    compare(4'd5, 0);
    chk("R10 reset overall", latest_all_q, 32'd0);

    // R1 activate opens bank 2 with row 0x1234
    do_cmd(4'd5, 2, 16'h1234, 32'd10, 32'd12);
    compare(4'd5, 2);
    chk("R1 bank2 open", 32'(open_mask[2]), 32'd1);
    chk("R11 bank2 row", 32'(open_row_q), 32'h1234);
    chk("R6 latest activate", latest_cmd_q, 32'd10);

    // R4 plain read, refresh, no-op and unused code keep state
    do_cmd(4'd1, 2, 16'h0, 32'd20, 32'd24);
    do_cmd(4'd8, 2, 16'h0, 32'd30, 32'd31);
    do_cmd(4'd0, 2, 16'h0, 32'd90, 32'd91);
    do_cmd(4'd12, 2, 16'h0, 32'd95, 32'd96);
    compare(4'd8, 2);
    chk("R4 bank2 still open", 32'(open_mask[2]), 32'd1);
    chk("R4 no-op not recorded", latest_all_q, 32'd30);

    // R2 precharge closes only its bank
    do_cmd(4'd5, 3, 16'h0077, 32'd40, 32'd41);
    do_cmd(4'd6, 3, 16'h0, 32'd45, 32'd46);
    compare(4'd6, 3);
    chk("R2 bank3 closed, bank2 open", 32'(open_mask), 32'h04);

    // R3 precharge-all
    do_cmd(4'd5, 5, 16'h0055, 32'd50, 32'd51);
    do_cmd(4'd7, 0, 16'h0, 32'd55, 32'd56);
    compare(4'd7, 5);
    chk("R3 all closed", 32'(open_mask), 32'd0);

    // R9 activate ring overflow
    do_reset();
    for (int i = 0; i < 9; i++) do_cmd(4'd5, i % NB, 16'(i), 32'(100 + i), 32'(101 + i));
    compare(4'd5, 0);
    chk("R9 ring full", 32'(act_count), 32'd8);
    chk("R9 overflow set", 32'(act_ovf), 32'd1);
    chk("R5 bank0 overwritten", latest_bank_q, 32'd108);

    // R10 reset clears sticky flag
    do_reset();
    compare(4'd5, 0);
    chk("R10 overflow cleared", 32'(act_ovf), 32'd0);

    // R7 activate window boundaries
    act_window = 32'd100;
    do_cmd(4'd5, 1, 16'h1, 32'd50, 32'd51);
    do_cmd(4'd5, 2, 16'h2, 32'd60, 32'd61);
    do_prune(32'd80);
    compare(4'd5, 1);
    chk("R7 T below window keeps all", 32'(act_count), 32'd2);
    do_prune(32'd150);
    compare(4'd5, 1);
    chk("R7 start equal T-W kept", 32'(act_count), 32'd2);
    do_prune(32'd151);
    compare(4'd5, 1);
    chk("R7 start below T-W dropped", 32'(act_count), 32'd1);

    // R8 transfer window boundaries
    do_reset();
    xfer_window = 32'd10;
    do_cmd(4'd1, 0, 16'h0, 32'd90, 32'd100);
    do_cmd(4'd3, 1, 16'h0, 32'd190, 32'd200);
    do_prune(32'd110);
    compare(4'd1, 0);
    chk("R8 distance equal window kept", 32'(xfer_count), 32'd2);
    do_prune(32'd111);
    compare(4'd1, 0);
    chk("R8 distance above window dropped, future end kept", 32'(xfer_count), 32'd1);

    // mixed random traffic
    do_reset();
    act_window = 32'd40;
    xfer_window = 32'd25;
    now = 32'd1;
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [3:0] code;
      now = now + 32'(1 + $urandom % 20);
      r = int'($urandom % 100);
      if (r < 15) begin
        do_prune(now + 32'($urandom % 8));
      end else begin
        code = (r < 45) ? 4'd5 : 4'($urandom % 16);
        do_cmd(code, int'($urandom % NB), 16'($urandom), now, now + 32'(4 + $urandom % 8));
      end
      compare(4'($urandom % 16), int'($urandom % NB));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule